// File: doc/BRIEF.md
# I2C Register-Pointer Slave

This block is a target device on a two-wire serial bus. It lets an external master read and write a small register file through an internal byte pointer. SCL and SDA come in from open-drain pads, pass through a synchroniser, and are oversampled by the system clock. Edge logic finds START, repeated START and STOP conditions. A byte engine then shifts bits in and out, matches the fixed 7-bit address, and drives acknowledges. The block only ever pulls SDA low, through `sda_oe`. Releasing SDA is left to the pull-up.

A write transaction begins with the address byte, direction bit 0. The next byte sets the pointer. Every later byte is stored at the pointer, and the pointer then advances. A read transaction, direction bit 1, streams bytes out starting at the pointer and advances it after each byte. The pointer survives STOP, so a read that does not first set the pointer continues from wherever the last transaction left it.

The register file lies outside the block. The block reaches it through an address, a write strobe, write data and a read-data return. Read data must be valid by the SCL falling edge that follows a pointer change. The pointer is held steady for at least one bit time before that edge.

Top module: `i2c_regptr_slave`

## Requirements
- R1: Out of reset, `sda_oe` is 0, `reg_we` is 0, and `reg_addr` (the pointer) is 0x00.
- R2: The first byte after a START is the address byte, sent MSB first. Bits [7:1] hold the address and bit 0 holds the direction, where 0 means write and 1 means read. When bits [7:1] equal 1101000, the block acknowledges by holding SDA low through the ninth SCL pulse.
- R3: On an address mismatch, the block leaves SDA released (no acknowledge, no data) and writes no register. It stays silent until the next START, and the pointer keeps its value.
- R4: In a write transaction, the first byte after the address byte is loaded into the pointer and acknowledged. It is never written to a register.
- R5: Each later write byte is acknowledged and produces exactly one single-cycle `reg_we` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then increments by one. A write that stops right after the pointer byte is legal.
- R6: In a read transaction, bytes are driven MSB first, starting with the register at the pointer. The pointer increments by one for each byte sent.
- R7: The pointer keeps its value across STOP. A read with no preceding pointer write starts where the last transaction left the pointer.
- R8: When the master answers a read byte with a not-acknowledge (SDA high on the ninth pulse), the block releases SDA and drives nothing more until the next START. The pointer is not advanced further.
- R9: A repeated START ends the current transfer at once. The next byte is treated as a fresh address byte.
- R10: The 8-bit pointer wraps from 0xFF to 0x00, both on writes and on reads.
- R11: `sda_oe` changes only while SCL is low. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level read from the pad |
| sda_i | input | 1 | SDA level read from the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | PTR_W | Register address, equal to the current pointer |
| reg_wdata | output | 8 | Byte to store while `reg_we` is high |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_rdata | input | 8 | Register contents at `reg_addr` |

## Verification
The bench builds the block with its default parameters: address 1101000, an 8-bit pointer and two synchroniser stages. The SCL period is 20 system clocks, which leaves room for the synchroniser and detect latency inside each SCL low phase. Because the pointer is only 8 bits wide, the wrap from 0xFF to 0x00 is reachable with a handful of bytes, on both writes and reads. The fixed address lets a single bit flip exercise mismatched addresses in both directions. Repeated START is exercised in two places: after a pointer write, and after a rejected address.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,   // ignoring the bus until a START
    ST_RX,     // shifting a byte in
    ST_ACK,    // driving the acknowledge for a received byte
    ST_TX,     // shifting a byte out
    ST_MACK,   // waiting for the master's acknowledge
    ST_LOAD    // master acknowledged, load next byte at SCL fall
  } rp_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,   // next byte is address + direction
    PH_PTR,    // next byte sets the pointer
    PH_WR,     // next byte is stored
    PH_RD      // bytes are sent
  } rp_phase_e;

  // Address field occupies bits [7:1] of the first byte.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [6:0] own);
    return b[BYTE_W-1:1] == own;
  endfunction

  // Direction bit: 1 selects read.
  function automatic logic dir_read(input logic [BYTE_W-1:0] b);
    return b[0];
  endfunction

endpackage

// File: rtl/i2c_rp_line_sync.sv
module i2c_rp_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  // Idle bus is high on both lines, so every stage resets to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe[0] <= scl_i;
      sda_pipe[0] <= sda_i;
      for (int i = 1; i < STAGES; i++) begin
        scl_pipe[i] <= scl_pipe[i-1];
        sda_pipe[i] <= sda_pipe[i-1];
      end
      scl_q <= scl_pipe[STAGES-1];
      sda_q <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  // Conditions need SCL high on both samples around the SDA edge.
  assign start_det = scl_s & scl_q &  sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/i2c_rp_ptr.sv
module i2c_rp_ptr #(
  parameter int unsigned PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return p + 1'b1;  // natural wrap at the top of the range
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr_step(ptr);
  end

  AST_LOAD_INC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && inc)); // R4

endmodule

// File: rtl/i2c_regptr_slave.sv
module i2c_regptr_slave
  import i2c_rp_pkg::*;
#(
  parameter logic [6:0]  SLAVE_ADDR  = 7'b1101000,
  parameter int unsigned PTR_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [PTR_W-1:0] reg_addr,
  output logic [7:0]       reg_wdata,
  output logic             reg_we,
  input  logic [7:0]       reg_rdata
);

  localparam int unsigned      CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

  // Bus events, named for the assertions.
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_rp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  rp_state_e          state_q;
  rp_phase_e          phase_q;
  logic [CNT_W-1:0]   bit_cnt_q;
  logic [BYTE_W-2:0]  rx_sh_q;
  logic [BYTE_W-2:0]  tx_sh_q;
  logic               sda_oe_q;
  logic               we_q;
  logic [BYTE_W-1:0]  wdata_q;
  logic [PTR_W-1:0]   ptr;

  logic [BYTE_W-1:0]  rx_byte;
  logic               byte_done;
  logic               tx_load;
  logic               ptr_load;
  logic               ptr_inc;

  assign rx_byte   = {rx_sh_q, sda_s};
  assign byte_done = (state_q == ST_RX) && scl_rise && (bit_cnt_q == LAST_BIT);
  assign tx_load   = scl_fall &&
                     (((state_q == ST_ACK) && sda_oe_q && (phase_q == PH_RD)) ||
                      (state_q == ST_LOAD));
  assign ptr_load  = byte_done && (phase_q == PH_PTR);
  // A stored byte advances the pointer one cycle after the strobe;
  // a sent byte advances it as the byte is captured for shifting.
  assign ptr_inc   = we_q || tx_load;

  i2c_rp_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (rx_byte[PTR_W-1:0]),
    .inc      (ptr_inc),
    .ptr      (ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_ADDR;
      bit_cnt_q <= '0;
      rx_sh_q   <= '0;
      tx_sh_q   <= '0;
      sda_oe_q  <= 1'b0;
      we_q      <= 1'b0;
      wdata_q   <= '0;
    end else begin
      we_q <= 1'b0;
      if (start_det) begin
        state_q   <= ST_RX;
        phase_q   <= PH_ADDR;
        bit_cnt_q <= '0;
        sda_oe_q  <= 1'b0;
      end else if (stop_det) begin
        state_q  <= ST_IDLE;
        sda_oe_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_RX: begin
            if (scl_rise) begin
              rx_sh_q   <= rx_byte[BYTE_W-2:0];
              bit_cnt_q <= bit_cnt_q + 1'b1;
              if (byte_done) begin
                unique case (phase_q)
                  PH_ADDR: begin
                    if (addr_hit(rx_byte, SLAVE_ADDR)) begin
                      state_q <= ST_ACK;
                      phase_q <= dir_read(rx_byte) ? PH_RD : PH_PTR;
                    end else begin
                      state_q <= ST_IDLE;
                    end
                  end
                  PH_PTR: begin
                    state_q <= ST_ACK;
                    phase_q <= PH_WR;
                  end
                  default: begin
                    state_q <= ST_ACK;
                    we_q    <= 1'b1;
                    wdata_q <= rx_byte;
                  end
                endcase
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (!sda_oe_q) begin
                sda_oe_q <= 1'b1;
              end else if (phase_q == PH_RD) begin
                tx_sh_q   <= reg_rdata[BYTE_W-2:0];
                sda_oe_q  <= ~reg_rdata[BYTE_W-1];
                bit_cnt_q <= '0;
                state_q   <= ST_TX;
              end else begin
                sda_oe_q  <= 1'b0;
                bit_cnt_q <= '0;
                state_q   <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) bit_cnt_q <= bit_cnt_q + 1'b1;
            if (scl_fall) begin
              if (bit_cnt_q == ALL_BITS) begin
                sda_oe_q <= 1'b0;
                state_q  <= ST_MACK;
              end else begin
                sda_oe_q <= ~tx_sh_q[BYTE_W-2];
                tx_sh_q  <= {tx_sh_q[BYTE_W-3:0], 1'b0};
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) state_q <= sda_s ? ST_IDLE : ST_LOAD;
          end
          ST_LOAD: begin
            if (scl_fall) begin
              tx_sh_q   <= reg_rdata[BYTE_W-2:0];
              sda_oe_q  <= ~reg_rdata[BYTE_W-1];
              bit_cnt_q <= '0;
              state_q   <= ST_TX;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe    = sda_oe_q;
  assign reg_we    = we_q;
  assign reg_wdata = wdata_q;
  assign reg_addr  = ptr;

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe != $past(sda_oe)) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s)); // R11
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R5
  AST_WE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(scl_rise)); // R5
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (reg_addr == PTR_W'($past(reg_addr) + 1'b1))); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_oe); // R3

endmodule

// File: tb/i2c_regptr_slave_tb_top.sv
module i2c_regptr_slave_tb_top;

  localparam int Q = 5;  // quarter SCL period in system clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [7:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_we;
  logic [7:0] reg_rdata;
  logic       sda_bus;

  logic [7:0] tb_mem  [256];
  logic [7:0] exp_mem [256];
  logic [7:0] exp_ptr = 8'h00;
  logic [15:0] exp_q [$];

  int n_chk = 0;
  int n_err = 0;
  int oe_viol = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  assign sda_bus   = sda_m & ~sda_oe;
  assign reg_rdata = tb_mem[reg_addr];

  i2c_regptr_slave dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_bus),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata)
  );

  initial begin
    for (int i = 0; i < 256; i++) begin
      tb_mem[i]  = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
  end

  always @(posedge clk) if (reg_we) tb_mem[reg_addr] <= reg_wdata;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: each write strobe must match the next expected item.
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (exp_q.size() == 0) begin
        chk("R3/R4 unexpected write", {reg_addr, reg_wdata}, 16'hxxxx);
      end else begin
        logic [15:0] it;
        it = exp_q.pop_front();
        chk("R5 write addr/data", {reg_addr, reg_wdata}, it);
      end
    end
  end

  // R11 monitor: output may change only while SCL is low.
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== oe_prev) && scl_m) oe_viol++;
    oe_prev <= sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~give_ack);
  endtask

  // Driver: write transaction, pushes expected strobes into the scoreboard.
  task automatic wr_txn(input logic [7:0] p, input logic [31:0] dat, input int n,
                        input bit do_stop);
    logic ack;
    logic [7:0] d;
    bus_start();
    put_byte(8'hD0, ack); chk("R2 write address ack", ack, 1);
    put_byte(p, ack);     chk("R4 pointer byte ack", ack, 1);
    exp_ptr = p;
    for (int i = 0; i < n; i++) begin
      d = dat[31 - 8*i -: 8];
      exp_q.push_back({exp_ptr, d});
      exp_mem[exp_ptr] = d;
      exp_ptr = exp_ptr + 8'd1;
      put_byte(d, ack);   chk("R5 data byte ack", ack, 1);
    end
    if (do_stop) bus_stop();
  endtask

  task automatic rd_txn(input int n, input string req, input bit do_stop);
    logic ack;
    logic [7:0] d;
    bus_start();
    put_byte(8'hD1, ack); chk("R2 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(d, i != n - 1);
      chk(req, d, exp_mem[exp_ptr]);
      exp_ptr = exp_ptr + 8'd1;
    end
    if (do_stop) bus_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    tick(4);
    chk("R1 sda_oe reset", sda_oe, 0);
    chk("R1 reg_we reset", reg_we, 0);
    chk("R1 pointer reset", reg_addr, 0);
    rst_n = 1'b1;
    tick(4);

    // Basic write and pointer retention
    wr_txn(8'h10, 32'hA1B2C300, 3, 1'b1);
    chk("R7 pointer after write", reg_addr, exp_ptr);
    rd_txn(2, "R6/R7 read resumes at pointer", 1'b1);
    chk("R6 pointer after read", reg_addr, exp_ptr);

    // Pointer write then repeated START read
    wr_txn(8'h11, 32'h0, 0, 1'b0);
    rd_txn(3, "R9 read after repeated START", 1'b1);

    // Wrap on write and on read; zero-data write
    wr_txn(8'hFE, 32'h11223300, 3, 1'b1);
    chk("R10 pointer wrapped on write", reg_addr, 8'h01);
    wr_txn(8'hFF, 32'h0, 0, 1'b1);
    chk("R5 zero-data write sets pointer", reg_addr, 8'hFF);
    rd_txn(2, "R10 read across wrap", 1'b1);
    chk("R10 pointer wrapped on read", reg_addr, 8'h01);

    // Address mismatch, both directions
    bus_start();
    put_byte(8'hD2, ack); chk("R3 mismatch write no ack", ack, 0);
    put_byte(8'h33, ack); chk("R3 ignored byte no ack", ack, 0);
    bus_stop();
    bus_start();
    put_byte(8'h51, ack); chk("R3 mismatch read no ack", ack, 0);
    get_byte(d, 1'b0);    chk("R3 no data driven", d, 8'hFF);
    bus_stop();
    chk("R3 pointer untouched", reg_addr, exp_ptr);

    // NACK ends a read
    rd_txn(2, "R8 read before nack", 1'b0);
    get_byte(d, 1'b0);    chk("R8 released after nack", d, 8'hFF);
    bus_stop();
    chk("R8 pointer after nack", reg_addr, exp_ptr);

    // Mismatch followed by repeated START with a good address
    bus_start();
    put_byte(8'hA0, ack); chk("R3 foreign address no ack", ack, 0);
    wr_txn(8'h40, 32'h5A000000, 1, 1'b1);
    rd_txn(1, "R9 readback after restart", 1'b1);

    tick(20);
    chk("R5 all expected writes seen", exp_q.size(), 0);
    chk("R11 sda_oe changed with SCL high", oe_viol, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule